// File: doc/BRIEF.md
# Paged PHY Register Access Sequencer

This block turns a flat 16-bit PHY register address into the two management frames needed by a PHY whose register map is split into pages. A request carries a PHY address, a 16-bit register address, a direction and write data. The sequencer first writes the upper byte of the address (the low byte cleared) into the PHY's page-select register at management address 31. It then performs the real read or write at the five low address bits. It reports the outcome on a single-cycle done pulse with read data and an error flag.

The management-frame serializer sits outside the block. It is driven through a command port (valid/ready) and answers each frame with a one-cycle result pulse. Every frame uses a fixed clock divisor of 0x3E. A PHY address above 31 is refused without touching the bus. A failed page-select frame ends the request at once, and the access frame is not sent.

Back-pressure rules: a request is taken on the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle after `rsp_done`. The command port holds every field steady while `cmd_valid` is high and `cmd_ready` is low. `cmd_valid` never drops without a handshake.

Top module: `paged_phy_access`

## Requirements
- R1: After reset, `req_ready` is 1, and `cmd_valid` and `rsp_done` are 0.
- R2: `req_ready` is 0 from the cycle after a request is accepted until `rsp_done` has pulsed. While `rsp_done` or `cmd_valid` is high, `req_ready` is 0.
- R3: For a request whose PHY address is at most 31, the first frame is a write (`cmd_write`=1) to `cmd_reg`=31 on the request's PHY address. Its data is the register address ANDed with 0xFF00, and `cmd_div` is 0x3E. The frame appears in the cycle after acceptance.
- R4: The second frame carries `cmd_reg` = register address bits 4:0 and `cmd_write` = the request direction (1 = write), with `cmd_div` = 0x3E. On a write, `cmd_data` is the write data. On a read, `cmd_data` is 0. Address bits 7:5 affect neither frame.
- R5: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and all command fields hold their values.
- R6: `rsp_done` is high for exactly one cycle, in the cycle after the access frame's result pulse. `rsp_err` then equals the result's error bit. For an error-free read, `rsp_rdata` equals the result data.
- R7: A PHY address above 31 issues no frame and gives `rsp_done`=1 with `rsp_err`=1 in the cycle after acceptance.
- R8: If the page-select frame's result reports an error, no access frame is issued. `rsp_done` follows with `rsp_err`=1.
- R9: The page-select frame is issued on every request, even when consecutive requests address the same page of the same PHY.
- R10: `rsp_rdata` is 0 for a write response and for any response with `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_phy | input | 8 | Target PHY address (values above 31 refused) |
| req_addr | input | 16 | Flat register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request failed (valid with rsp_done) |
| rsp_rdata | output | 16 | Read data (valid with rsp_done) |
| cmd_valid | output | 1 | Frame command offered to serializer |
| cmd_ready | input | 1 | Serializer takes the command |
| cmd_write | output | 1 | Frame direction, 1 = write |
| cmd_phy | output | 5 | Frame PHY address |
| cmd_reg | output | 5 | Frame register address |
| cmd_data | output | 16 | Frame write data |
| cmd_div | output | 7 | Clock divisor for the frame |
| res_valid | input | 1 | One-cycle frame result pulse |
| res_err | input | 1 | Frame failed |
| res_rdata | input | 16 | Frame read data |

## Verification
The bench builds the block with its default parameters. The request PHY port is 8 bits wide, wider than the 5-bit frame field, so addresses 32 and 255 can reach the refusal path. A behavioural serializer in the bench stalls `cmd_ready` for a chosen number of cycles, which tests field stability under back-pressure. It also injects errors into either the page-select frame or the access frame. Read data is derived from the page the serializer last saw, so a missing or wrong page write shows up as wrong data.

// File: rtl/paged_pkg.sv
package paged_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PAGE_CMD  = 3'd1,
    ST_PAGE_WAIT = 3'd2,
    ST_ACC_CMD   = 3'd3,
    ST_ACC_WAIT  = 3'd4,
    ST_RESP      = 3'd5
  } seq_state_e;
endpackage

// File: rtl/paged_req_check.sv
// Splits a flat request into page value and in-page offset, and checks the PHY address range.
module paged_req_check #(
  parameter int PHY_IN_W = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter logic [DATA_W-1:0] PAGE_MASK = 16'hFF00
) (
  input  logic [PHY_IN_W-1:0] phy_in,
  input  logic [DATA_W-1:0]   addr_in,
  output logic                phy_ok,
  output logic [ADDR_W-1:0]   phy_out,
  output logic [DATA_W-1:0]   page_val,
  output logic [ADDR_W-1:0]   offset
);
  generate
    if (PHY_IN_W > ADDR_W) begin : g_wide
      assign phy_ok = ~|phy_in[PHY_IN_W-1:ADDR_W];
    end else begin : g_narrow
      assign phy_ok = 1'b1;
    end
  endgenerate

  assign phy_out  = phy_in[ADDR_W-1:0];
  assign page_val = addr_in & PAGE_MASK;
  assign offset   = addr_in[ADDR_W-1:0];
endmodule

// File: rtl/paged_frame_seq.sv
// Two-frame sequencer: page-select write, then the real access.
module paged_frame_seq
  import paged_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 7,
  parameter logic [DIV_W-1:0]  MDC_DIV  = 7'h3E,
  parameter logic [ADDR_W-1:0] PAGE_REG = 5'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              chk_phy_ok,
  input  logic [ADDR_W-1:0] chk_phy,
  input  logic [DATA_W-1:0] chk_page,
  input  logic [ADDR_W-1:0] chk_off,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_phy,
  output logic [ADDR_W-1:0] cmd_reg,
  output logic [DATA_W-1:0] cmd_data,
  output logic [DIV_W-1:0]  cmd_div,
  input  logic              res_valid,
  input  logic              res_err,
  input  logic [DATA_W-1:0] res_rdata
);
  seq_state_e        state;
  logic [ADDR_W-1:0] r_phy;
  logic [ADDR_W-1:0] r_off;
  logic [DATA_W-1:0] r_page;
  logic              r_write;
  logic [DATA_W-1:0] r_wdata;
  logic              r_err;
  logic [DATA_W-1:0] r_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_phy   <= '0;
      r_off   <= '0;
      r_page  <= '0;
      r_write <= 1'b0;
      r_wdata <= '0;
      r_err   <= 1'b0;
      r_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_phy   <= chk_phy;
            r_off   <= chk_off;
            r_page  <= chk_page;
            r_write <= req_write;
            r_wdata <= req_wdata;
            if (!chk_phy_ok) begin
              r_err   <= 1'b1;
              r_rdata <= '0;
              state   <= ST_RESP;
            end else begin
              state <= ST_PAGE_CMD;
            end
          end
        end
        ST_PAGE_CMD: if (cmd_ready) state <= ST_PAGE_WAIT;
        ST_PAGE_WAIT: begin
          if (res_valid) begin
            if (res_err) begin
              r_err   <= 1'b1;
              r_rdata <= '0;
              state   <= ST_RESP;
            end else begin
              state <= ST_ACC_CMD;
            end
          end
        end
        ST_ACC_CMD: if (cmd_ready) state <= ST_ACC_WAIT;
        ST_ACC_WAIT: begin
          if (res_valid) begin
            r_err   <= res_err;
            r_rdata <= (!r_write && !res_err) ? res_rdata : '0;
            state   <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_done  = (state == ST_RESP);
    rsp_err   = r_err;
    rsp_rdata = r_rdata;
    cmd_valid = (state == ST_PAGE_CMD) || (state == ST_ACC_CMD);
    cmd_phy   = r_phy;
    cmd_div   = MDC_DIV;
    if (state == ST_PAGE_CMD) begin
      cmd_write = 1'b1;
      cmd_reg   = PAGE_REG;
      cmd_data  = r_page;
    end else begin
      cmd_write = r_write;
      cmd_reg   = r_off;
      cmd_data  = r_write ? r_wdata : '0;
    end
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_reg) && $stable(cmd_data)
                                   && $stable(cmd_write) && $stable(cmd_phy)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R8
  page_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAGE_WAIT && res_valid && res_err) |=> (rsp_done && rsp_err && !cmd_valid));
  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || cmd_valid) |-> !req_ready);
  // R10
  wr_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_err || r_write)) |-> (rsp_rdata == '0));
endmodule

// File: rtl/paged_phy_access.sv
module paged_phy_access #(
  parameter int PHY_IN_W = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 7,
  parameter logic [DIV_W-1:0]  MDC_DIV   = 7'h3E,
  parameter logic [ADDR_W-1:0] PAGE_REG  = 5'h1F,
  parameter logic [DATA_W-1:0] PAGE_MASK = 16'hFF00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PHY_IN_W-1:0] req_phy,
  input  logic [DATA_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_write,
  output logic [ADDR_W-1:0]   cmd_phy,
  output logic [ADDR_W-1:0]   cmd_reg,
  output logic [DATA_W-1:0]   cmd_data,
  output logic [DIV_W-1:0]    cmd_div,
  input  logic                res_valid,
  input  logic                res_err,
  input  logic [DATA_W-1:0]   res_rdata
);
  logic              phy_ok;
  logic [ADDR_W-1:0] phy_lo;
  logic [DATA_W-1:0] page_val;
  logic [ADDR_W-1:0] offset;

  paged_req_check #(
    .PHY_IN_W(PHY_IN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_MASK(PAGE_MASK)
  ) i_check (
    .phy_in(req_phy), .addr_in(req_addr), .phy_ok(phy_ok),
    .phy_out(phy_lo), .page_val(page_val), .offset(offset)
  );

  paged_frame_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .MDC_DIV(MDC_DIV), .PAGE_REG(PAGE_REG)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .chk_phy_ok(phy_ok), .chk_phy(phy_lo), .chk_page(page_val), .chk_off(offset),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_div(cmd_div),
    .res_valid(res_valid), .res_err(res_err), .res_rdata(res_rdata)
  );

  // R3
  page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && phy_ok) |=>
      (cmd_valid && cmd_write && cmd_reg == PAGE_REG && cmd_div == MDC_DIV));
  // R7
  bad_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !phy_ok) |=> (rsp_done && rsp_err && !cmd_valid));
endmodule

// File: tb/test_paged_phy_access.sv
module test_paged_phy_access;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        kind;   // 0 page-select, 1 access
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic [6:0]  div;
  } frame_t;

  typedef struct packed {
    logic        err;
    logic [15:0] rdata;
  } resp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_phy = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic cmd_valid, cmd_write;
  logic cmd_ready = 1'b0;
  logic [4:0] cmd_phy, cmd_reg;
  logic [15:0] cmd_data;
  logic [6:0] cmd_div;
  logic res_valid = 1'b0, res_err = 1'b0;
  logic [15:0] res_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_phy_access i_paged_phy_access (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_div(cmd_div),
    .res_valid(res_valid), .res_err(res_err), .res_rdata(res_rdata)
  );

  int total = 0, bad = 0, rsp_seen = 0;
  int stall = 0, lat = 0;
  bit fail_page = 0, fail_acc = 0, finished = 0;
  frame_t frame_q[$];
  resp_t  resp_q[$];
  logic [15:0] srv_page [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic frame_t cur_frame(input logic kind);
    frame_t f;
    f.kind = kind; f.wr = cmd_write; f.phy = cmd_phy; f.rg = cmd_reg;
    f.data = cmd_data; f.div = cmd_div;
    return f;
  endfunction

  // Behavioural serializer and frame monitor
  initial begin
    for (int i = 0; i < 32; i++) srv_page[i] = '0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        frame_t snap, exp_f;
        bit     e;
        snap = cur_frame(1'b0);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(cmd_valid && cur_frame(1'b0) == snap, "R5", "held command",
              32'(cur_frame(1'b0)), 32'(snap));
        end
        if (frame_q.size() == 0) begin
          chk(1'b0, "R7/R8", "unexpected frame", 32'(snap), 32'h0);
          exp_f = snap;
        end else begin
          exp_f = frame_q.pop_front();
          snap.kind = exp_f.kind;
          chk(snap == exp_f, exp_f.kind ? "R4" : "R3", "frame fields",
              {snap.wr, snap.rg, snap.data, 5'(snap.div)},
              {exp_f.wr, exp_f.rg, exp_f.data, 5'(exp_f.div)});
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        e = exp_f.kind ? fail_acc : fail_page;
        if (!exp_f.kind && !e) srv_page[snap.phy] = snap.data;
        for (int l = 0; l < lat; l++) @(negedge clk);
        res_valid = 1'b1;
        res_err   = e;
        res_rdata = srv_page[snap.phy] ^ {11'b0, snap.rg} ^ 16'hA5A5;
        @(negedge clk);
        res_valid = 1'b0;
        res_err   = 1'b0;
      end
    end
  end

  // Response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_done) begin
        resp_t r;
        r = (resp_q.size() != 0) ? resp_q.pop_front() : '0;
        chk(rsp_err == r.err, "R6", "rsp_err", 32'(rsp_err), 32'(r.err));
        chk(rsp_rdata == r.rdata, "R6/R10", "rsp_rdata", 32'(rsp_rdata), 32'(r.rdata));
        chk(!req_ready, "R2", "ready during done", 32'(req_ready), 32'h0);
        @(negedge clk);
        chk(!rsp_done, "R6", "done one cycle", 32'(rsp_done), 32'h0);
        rsp_seen++;
      end
    end
  end

  task automatic do_req(input logic [7:0] phy, input logic [15:0] addr, input bit wr,
                        input logic [15:0] wd, input bit pfail, input bit afail,
                        input int st, input int lt);
    frame_t f;
    resp_t  r;
    int     target;
    fail_page = pfail; fail_acc = afail; stall = st; lat = lt;
    if (phy > 8'd31) begin
      r.err = 1'b1; r.rdata = '0;
    end else begin
      f.kind = 1'b0; f.wr = 1'b1; f.phy = phy[4:0]; f.rg = 5'd31;
      f.data = addr & 16'hFF00; f.div = 7'h3E;
      frame_q.push_back(f);
      if (pfail) begin
        r.err = 1'b1; r.rdata = '0;
      end else begin
        f.kind = 1'b1; f.wr = wr; f.rg = addr[4:0];
        f.data = wr ? wd : 16'h0;
        frame_q.push_back(f);
        r.err = afail;
        r.rdata = (wr || afail) ? 16'h0
                : ((addr & 16'hFF00) ^ {11'b0, addr[4:0]} ^ 16'hA5A5);
      end
    end
    resp_q.push_back(r);
    target = rsp_seen + 1;
    @(negedge clk);
    req_valid = 1'b1; req_phy = phy; req_addr = addr; req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready after accept", 32'(req_ready), 32'h0);
    if (phy > 8'd31)
      chk(rsp_done && rsp_err && !cmd_valid, "R7", "refusal timing",
          {rsp_done, rsp_err, cmd_valid}, 32'h6);
    while (rsp_seen < target) @(negedge clk);
    chk(frame_q.size() == 0, "R8", "frames left", 32'(frame_q.size()), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !rsp_done, "R1", "reset outputs",
        {req_ready, cmd_valid, rsp_done}, 32'h4);
    do_req(8'd5,  16'h1234, 1'b1, 16'hBEEF, 0, 0, 0, 0);  // R3 R4 write
    do_req(8'd5,  16'hABCD, 1'b0, 16'h0,    0, 0, 2, 1);  // R4 R6 read with stall
    do_req(8'd6,  16'h00E3, 1'b0, 16'h0,    0, 0, 0, 3);  // R4 bits 7:5 ignored
    do_req(8'd6,  16'h0003, 1'b0, 16'h0,    0, 0, 1, 0);  // R9 same page repeated
    do_req(8'd6,  16'h0017, 1'b1, 16'h5A5A, 0, 0, 3, 0);  // R9 R10 write rdata 0
    do_req(8'd32, 16'h4411, 1'b1, 16'h1111, 0, 0, 0, 0);  // R7 just above limit
    do_req(8'd255,16'hFF1F, 1'b0, 16'h0,    0, 0, 0, 0);  // R7 max value
    do_req(8'd31, 16'h7F1F, 1'b1, 16'h2222, 1, 0, 1, 2);  // R8 page fail on write
    do_req(8'd0,  16'h8001, 1'b0, 16'h0,    1, 0, 0, 0);  // R8 page fail on read
    do_req(8'd3,  16'h2208, 1'b0, 16'h0,    0, 1, 0, 1);  // R6 R10 access error
    do_req(8'd31, 16'hFFFF, 1'b0, 16'h0,    0, 0, 4, 4);  // R3 R4 extreme address
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", rsp_seen, 11);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule